// File: doc/BRIEF.md
# Frame-Synchronized Time-Slot State Counter

This block keeps an 11-bit state counter that tracks the position inside a TDM frame, one step per bit clock. In normal use the counter starts again from zero each time a frame strobe arrives. The strobe comes either from an internal frame generator or from an external frame pin. The external pin may be asynchronous to the counter clock, so it is synchronized and edge-detected before use.

Two byte-wide diagnostic registers sit on a plain write/read register port. They select four test behaviours. Cycle test makes the frame groups run freely and exposes an enable for them. Carry break splits the counter into three independent counters. A third bit picks the external frame source. A modulo-n mode reloads from a register-held bound and stops following frame strobes.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. A register write takes effect at the clock edge on which `reg_wr` is sampled high.

Top module: `tslot_state_ctr`

## Requirements
- R1: After reset, `count` is 0, `cycle_en` is 0, and both diagnostic registers read 0.
- R2: With every mode bit clear, a selected frame strobe sampled at a clock edge makes `count` 0 after that edge. Without a strobe, `count` steps by one per clock and goes from 2047 to 0.
- R3: With the source-select bit (0x31 bit 5) clear, `frame_int` is the framing reference and `frame_ext` has no effect on `count`.
- R4: With the source-select bit set, `frame_int` has no effect. A rising level on `frame_ext` is taken through a two-flop synchronizer and a rising-edge detector. If the pin is first sampled high at edge k, `count` is 0 after edge k+2.
- R5: With the carry-break bit (0x31 bit 6) set, bits [3:0], [7:4] and [10:8] each step by one per clock, independently, modulo 16, 16 and 8. A selected frame strobe still clears all of them.
- R6: With the cycle-test bit (0x31 bit 7) set, `cycle_en` is 1 and frame strobes are ignored, so the counter runs freely.
- R7: With the modulo-n bit (0x31 bit 3) set, n = {0x31[2:0], 0x32[7:0]}. The counter goes to 0 when count+1 >= n and otherwise steps by one, so it counts 0..n-1. A value of n = 0 holds it at 0. Frame strobes are ignored in this mode.
- R8: When modulo-n and carry-break are both set, modulo-n behaviour applies.
- R9: Address 0x31 reads back {cycle, break, ext, 0, modn, load[10:8]}, with reserved bit 4 always reading 0. Address 0x32 reads load[7:0]. Any other address reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_int | input | 1 | Internally generated frame strobe, one clock wide |
| frame_ext | input | 1 | External frame pin, possibly asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| count | output | 11 | State counter value |
| cycle_en | output | 1 | Frame-group free-cycle enable |

## Verification
The counter is driven with long strobe-free stretches to reach the 2047 wrap, and with isolated strobes on each frame source while the other source toggles. This separates correct source selection from a counter that reacts to both sources. Modulo-n is run with n = 0, 1, 5 and with a bound below the current count, which tells an inclusive compare from an exclusive one. Combined mode bits show the mode priority. A seeded random phase mixes register writes, strobes and pin toggles against a bench model, which exposes segment-carry and synchronizer-latency mistakes.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int CNT_W  = 11;
  localparam int REG_W  = 8;
  localparam int HI_W   = CNT_W - REG_W;
  localparam logic [7:0] ADDR_CTRL = 8'h31;
  localparam logic [7:0] ADDR_LOAD = 8'h32;

  typedef struct packed {
    logic             cyc;
    logic             brk;
    logic             ext;
    logic             modn;
    logic [CNT_W-1:0] load;
  } tsc_cfg_t;
endpackage

// File: rtl/tsc_regs.sv
module tsc_regs
  import tsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [7:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output tsc_cfg_t         cfg
);
  logic            cyc_q, brk_q, ext_q, modn_q;
  logic [HI_W-1:0] hi_q;
  logic [REG_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q  <= 1'b0;
      brk_q  <= 1'b0;
      ext_q  <= 1'b0;
      modn_q <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (wr) begin
      if (addr == ADDR_CTRL) begin
        cyc_q  <= wdata[7];
        brk_q  <= wdata[6];
        ext_q  <= wdata[5];
        modn_q <= wdata[3];
        hi_q   <= wdata[HI_W-1:0];
      end else if (addr == ADDR_LOAD) begin
        lo_q <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_CTRL) begin
      rdata[7]        = cyc_q;
      rdata[6]        = brk_q;
      rdata[5]        = ext_q;
      rdata[3]        = modn_q;
      rdata[HI_W-1:0] = hi_q;
    end else if (addr == ADDR_LOAD) begin
      rdata = lo_q;
    end
  end

  assign cfg.cyc  = cyc_q;
  assign cfg.brk  = brk_q;
  assign cfg.ext  = ext_q;
  assign cfg.modn = modn_q;
  assign cfg.load = {hi_q, lo_q};
endmodule

// File: rtl/tsc_frame_sel.sv
module tsc_frame_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_ext,
  input  logic frame_int,
  input  logic frame_ext,
  output logic hit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= frame_ext;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) sync_q[s] <= 1'b0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign hit = use_ext ? (sync_q[SYNC_STAGES-1] & ~prev_q) : frame_int;
endmodule

// File: rtl/tsc_counter.sv
module tsc_counter #(
  parameter int CNT_W = 11,
  parameter int SEG_A = 4,
  parameter int SEG_B = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             cyc,
  input  logic             brk,
  input  logic             modn,
  input  logic [CNT_W-1:0] load,
  output logic [CNT_W-1:0] cnt
);
  localparam int NSEG = 3;
  localparam int LO[NSEG] = '{0, SEG_A, SEG_A + SEG_B};
  localparam int HI[NSEG] = '{SEG_A - 1, SEG_A + SEG_B - 1, CNT_W - 1};

  logic [CNT_W:0]   inc;
  logic [CNT_W-1:0] split;
  logic             wrap_n;

  assign inc    = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign wrap_n = inc >= {1'b0, load};

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam int W = HI[g] - LO[g] + 1;
    assign split[HI[g]:LO[g]] = cnt[HI[g]:LO[g]] + W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (modn)           cnt <= wrap_n ? '0 : inc[CNT_W-1:0];
    else if (hit && !cyc)    cnt <= '0;
    else if (brk)            cnt <= split;
    else                     cnt <= inc[CNT_W-1:0];
  end
endmodule

// File: rtl/tslot_state_ctr.sv
module tslot_state_ctr
  import tsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_int,
  input  logic             frame_ext,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [CNT_W-1:0] count,
  output logic             cycle_en
);
  tsc_cfg_t cfg;
  logic     frame_hit;

  tsc_regs i_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg)
  );

  tsc_frame_sel #(.SYNC_STAGES(2)) i_fsel (
    .clk(clk), .rst_n(rst_n), .use_ext(cfg.ext),
    .frame_int(frame_int), .frame_ext(frame_ext), .hit(frame_hit)
  );

  tsc_counter #(.CNT_W(CNT_W), .SEG_A(4), .SEG_B(4)) i_cnt (
    .clk(clk), .rst_n(rst_n), .hit(frame_hit), .cyc(cfg.cyc),
    .brk(cfg.brk), .modn(cfg.modn), .load(cfg.load), .cnt(count)
  );

  assign cycle_en = cfg.cyc;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [10:0] count,
  input logic        cyc,
  input logic        brk,
  input logic        modn,
  input logic [10:0] load,
  input logic        hit
);
  // R2: a selected strobe outside free-cycle and modulo-n clears the counter
  a_r2_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cyc && !modn) |=> (count == 11'd0));

  // R2: plain counting wraps from the top value to zero
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!modn && !brk && !(hit && !cyc) && count == 11'h7FF) |=> (count == 11'd0));

  // R5: independent low and top segments step by one
  a_r5_split_step: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !modn && !(hit && !cyc)) |=>
      (count[3:0] == 4'($past(count[3:0]) + 4'd1)) &&
      (count[10:8] == 3'($past(count[10:8]) + 3'd1)));

  // R6: free-cycle ignores strobes and keeps stepping
  a_r6_free_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && !modn && !brk) |=> (count == 11'($past(count) + 11'd1)));

  // R7, R8: modulo-n keeps the counter below the bound (or at 0 for n = 0)
  a_r7_modn_range: assert property (@(posedge clk) disable iff (!rst_n)
    (modn && !reg_wr) |=> ((load == 11'd0) ? (count == 11'd0) : (count < load)));
endmodule

bind tslot_state_ctr tsc_checker i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .count(count),
  .cyc(cfg.cyc), .brk(cfg.brk), .modn(cfg.modn), .load(cfg.load),
  .hit(frame_hit)
);

// File: tb/test_tslot_state_ctr.sv
module test_tslot_state_ctr;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_int = 1'b0;
  logic        frame_ext = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [10:0] count;
  logic        cycle_en;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0]  m_r2 = 8'h00, m_r3 = 8'h00;
  logic [10:0] m_cnt = 11'd0;
  logic        m_s1 = 1'b0, m_s2 = 1'b0, m_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tslot_state_ctr i_tslot_state_ctr (
    .clk(clk), .rst_n(rst_n), .frame_int(frame_int), .frame_ext(frame_ext),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .count(count), .cycle_en(cycle_en)
  );

  function automatic logic [10:0] model_next(logic [10:0] c, logic [7:0] r2,
                                             logic [7:0] r3, logic h);
    int n;
    n = {r2[2:0], r3};
    if (r2[3])             return ((int'(c) + 1) >= n) ? 11'd0 : c + 11'd1;
    else if (h && !r2[7])  return 11'd0;
    else if (r2[6])        return {c[10:8] + 3'd1, c[7:4] + 4'd1, c[3:0] + 4'd1};
    else                   return c + 11'd1;
  endfunction

  function automatic string tag_of(logic [7:0] r2);
    if (r2[3] && r2[6]) return "R8";
    if (r2[3])          return "R7";
    if (r2[7])          return "R6";
    if (r2[6])          return "R5";
    if (r2[5])          return "R4";
    return "R2";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // inputs already driven after a negedge; one clock, model update, compare
  task automatic tick(string tag);
    logic h;
    @(posedge clk);
    h = m_r2[5] ? (m_s2 & ~m_prev) : frame_int;
    m_cnt = model_next(m_cnt, m_r2, m_r3, h);
    if (reg_wr && reg_addr == 8'h31) m_r2 = reg_wdata & 8'hEF;
    if (reg_wr && reg_addr == 8'h32) m_r3 = reg_wdata;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = frame_ext;
    @(negedge clk);
    check(tag, int'(count), int'(m_cnt));
    check(tag, int'(cycle_en), int'(m_r2[7]));
    frame_int = 1'b0;
    reg_wr = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, string tag);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(tag);
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    reg_addr = a;
    #1;
    check(tag, int'(reg_rdata), int'(exp));
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", int'(count), 0);
    check("R1", int'(cycle_en), 0);
    rd(8'h31, 8'h00, "R1");
    rd(8'h32, 8'h00, "R1");

    // R9 readback, reserved bit, foreign address
    wr(8'h31, 8'hFF, "R9");
    rd(8'h31, 8'hEF, "R9");
    wr(8'h32, 8'h5A, "R9");
    rd(8'h32, 8'h5A, "R9");
    wr(8'h40, 8'hFF, "R9");
    rd(8'h40, 8'h00, "R9");
    rd(8'h31, 8'hEF, "R9");
    rd(8'h32, 8'h5A, "R9");
    wr(8'h31, 8'h00, "R9");
    wr(8'h32, 8'h00, "R9");

    // R2 strobe clear and full wrap
    frame_int = 1'b1; tick("R2");
    check("R2", int'(count), 0);
    run(2060, "R2");

    // R3 external pin ignored while internal source selected
    frame_ext = 1'b1; run(5, "R3");
    frame_ext = 1'b0; run(3, "R3");
    frame_ext = 1'b1; run(4, "R3");
    frame_ext = 1'b0;

    // R4 external source: internal strobe ignored, pin edge clears after sync
    wr(8'h31, 8'h20, "R4");
    run(20, "R4");
    frame_int = 1'b1; tick("R4");
    run(3, "R4");
    frame_ext = 1'b1; tick("R4"); tick("R4"); tick("R4");
    check("R4", int'(count), 0);
    run(6, "R4");
    frame_ext = 1'b0; run(4, "R4");

    // R6 free cycle
    wr(8'h31, 8'h80, "R6");
    run(7, "R6");
    frame_int = 1'b1; tick("R6");
    run(5, "R6");

    // R5 carry break, with one strobe inside
    wr(8'h31, 8'h40, "R5");
    run(25, "R5");
    frame_int = 1'b1; tick("R5");
    run(40, "R5");

    // R7 modulo-n: n=0, n=1, n=5, then a bound below the current count
    wr(8'h32, 8'h00, "R7");
    wr(8'h31, 8'h08, "R7");
    run(6, "R7");
    check("R7", int'(count), 0);
    wr(8'h32, 8'h01, "R7"); run(4, "R7");
    wr(8'h32, 8'h05, "R7");
    frame_int = 1'b1; run(12, "R7");
    wr(8'h31, 8'h00, "R7"); run(300, "R7");
    wr(8'h32, 8'h0A, "R7");
    wr(8'h31, 8'h08, "R7"); run(15, "R7");

    // R8 modulo-n over carry break
    wr(8'h32, 8'd20, "R8");
    wr(8'h31, 8'h48, "R8");
    run(45, "R8");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(39) == 0) begin
        reg_wr = 1'b1;
        reg_addr = ($urandom_range(1) == 0) ? 8'h31 : 8'h32;
        reg_wdata = 8'($urandom);
        if (reg_addr == 8'h31 && $urandom_range(3) != 0) reg_wdata[3] = 1'b0;
        if (reg_addr == 8'h32 && $urandom_range(1) == 0) reg_wdata = 8'($urandom_range(20));
      end
      if ($urandom_range(99) == 0) frame_int = 1'b1;
      if ($urandom_range(29) == 0) frame_ext = ~frame_ext;
      tick(tag_of(m_r2));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule